// File: doc/BRIEF.md
# I2C Bus Recovery Pulse Sequencer

This block frees a two-wire serial bus when a target device has been left in the middle of a byte and keeps the data line low. One start request launches a fixed pattern on two override outputs, one for the clock line and one for the data line. Each override, when 1, pulls its line low regardless of the normal bus controller; when 0 it leaves the line to the pull-up. The pattern gives the target nine full clock pulses so that it can finish its byte. It then pulls data low while the clock is low, lets the clock go high, and finally releases data, so that data rises while the clock is high. That last edge is a STOP condition.

Every step of the pattern lasts `PHASE_CYCLES` system clocks. With the default of 500 at 100 MHz, that is 5 us. The number of pulses is the parameter `PULSES` (nine by default). The sequencer reports `busy` while it runs and gives a one-cycle `done` when it finishes. The live clock and data line levels come back in on `scl_in` and `sda_in`. During the `done` cycle, `bus_ok` reports whether both lines read high, which tells the caller whether the recovery worked.

Top module: `bus_recovery_seq`

## Requirements
- R1: After reset, and at any time no recovery is running, `busy`, `done`, `scl_ovr` and `sda_ovr` are all 0.
- R2: A `start` level of 1 sampled on a rising clock edge while idle begins a recovery. `busy` is 1 from that edge until the final step ends.
- R3: The recovery opens with `PULSES` clock pulses. Each pulse is `PHASE_CYCLES` cycles with `scl_ovr`=0 followed by `PHASE_CYCLES` cycles with `scl_ovr`=1. `sda_ovr` stays 0 for the whole pulse train.
- R4: Directly after the last pulse comes one phase of `PHASE_CYCLES` cycles with `scl_ovr`=1 and `sda_ovr`=1. The data override therefore rises only while the clock override is already set.
- R5: Next comes one phase of `PHASE_CYCLES` cycles with `scl_ovr`=0 and `sda_ovr`=1.
- R6: Both overrides then return to 0 on the same edge. `sda_ovr` never falls while `scl_ovr` is 1 or was 1 in the previous cycle, so the data line rises with the clock line high (STOP).
- R7: `done` is 1 for exactly one cycle. That cycle begins (2*`PULSES`+2)*`PHASE_CYCLES` rising edges after the start edge, and `busy` falls on the same edge.
- R8: A `start` that is asserted while a recovery is running is ignored. The pattern and its timing are unchanged.
- R9: `bus_ok` equals `done` AND `scl_in` AND `sda_in`. It is 0 in every cycle without `done`.
- R10: If `start` is held at 1 continuously, the next recovery begins on the edge that ends the `done` cycle. There is exactly one idle cycle between two sequences.
- R11: The phase counter never reaches `PHASE_CYCLES`, and the pulse index never reaches `PULSES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Recovery request, sampled while idle |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| scl_ovr | output | 1 | Clock line override, 1 pulls the line low |
| sda_ovr | output | 1 | Data line override, 1 pulls the line low |
| scl_in | input | 1 | Live clock line level |
| sda_in | input | 1 | Live data line level |
| bus_ok | output | 1 | Both lines high during the `done` cycle |

## Verification
The embedded properties check the following on every cycle:
- the overrides are quiet whenever the block is idle;
- `done` lasts a single cycle and only follows a busy cycle;
- the data override rises only under a held clock override, and falls only with the clock released for two cycles;
- a start during a run leaves the step unchanged;
- the phase and pulse counters stay in range.

Only the bench scenarios can show the rest:
- the exact count of nine pulses;
- the length of each phase in cycles;
- the total latency to `done`;
- back-to-back restart under a held `start`;
- `bus_ok` against a modelled target that releases data after a chosen number of pulses, or never.

// File: rtl/bus_rec_pkg.sv
package bus_rec_pkg;

    // Steps of the recovery pattern, in the order they are visited.
    typedef enum logic [2:0] {
        STEP_IDLE     = 3'd0,
        STEP_CLK_HIGH = 3'd1,
        STEP_CLK_LOW  = 3'd2,
        STEP_DATA_LOW = 3'd3,
        STEP_CLK_REL  = 3'd4
    } rec_step_e;

    // Override pair: 1 in a field pulls that line low.
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    localparam int STEPS_PER_PULSE = 2;
    localparam int TAIL_STEPS      = 2;

    function automatic int total_phases(input int pulses);
        return STEPS_PER_PULSE * pulses + TAIL_STEPS;
    endfunction

    function automatic int count_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic line_drive_t drive_for(input rec_step_e step);
        line_drive_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        case (step)
            STEP_CLK_LOW:  d.scl_low = 1'b1;
            STEP_DATA_LOW: begin
                d.scl_low = 1'b1;
                d.sda_low = 1'b1;
            end
            STEP_CLK_REL:  d.sda_low = 1'b1;
            default:       d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rec_phase_timer.sv
module rec_phase_timer #(
    parameter int PHASE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic phase_end_o
);
    localparam int CW = bus_rec_pkg::count_width(PHASE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_end_o = run_i && (cnt_q == LAST);

    // R11
    phase_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < PHASE_CYCLES);

    // R2
    phase_cnt_parked_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/rec_step_seq.sv
module rec_step_seq
    import bus_rec_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      phase_end_i,
    output rec_step_e step_o,
    output logic      done_o
);
    localparam int PW = count_width(PULSES);
    localparam logic [PW-1:0] LAST_PULSE = PW'(PULSES - 1);

    rec_step_e step_q, step_d;
    logic [PW-1:0] pulse_q, pulse_d;
    logic done_q, done_d;

    always_comb begin
        step_d  = step_q;
        pulse_d = pulse_q;
        done_d  = 1'b0;
        case (step_q)
            STEP_IDLE: begin
                if (start_i) begin
                    step_d  = STEP_CLK_HIGH;
                    pulse_d = '0;
                end
            end
            STEP_CLK_HIGH: begin
                if (phase_end_i) step_d = STEP_CLK_LOW;
            end
            STEP_CLK_LOW: begin
                if (phase_end_i) begin
                    if (pulse_q == LAST_PULSE) begin
                        step_d = STEP_DATA_LOW;
                    end else begin
                        step_d  = STEP_CLK_HIGH;
                        pulse_d = pulse_q + 1'b1;
                    end
                end
            end
            STEP_DATA_LOW: begin
                if (phase_end_i) step_d = STEP_CLK_REL;
            end
            STEP_CLK_REL: begin
                if (phase_end_i) begin
                    step_d = STEP_IDLE;
                    done_d = 1'b1;
                end
            end
            default: step_d = STEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= STEP_IDLE;
            pulse_q <= '0;
            done_q  <= 1'b0;
        end else begin
            step_q  <= step_d;
            pulse_q <= pulse_d;
            done_q  <= done_d;
        end
    end

    assign step_o = step_q;
    assign done_o = done_q;

    // R11
    pulse_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(pulse_q) < PULSES);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && step_q != STEP_IDLE && !phase_end_i) |=> step_q == $past(step_q));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/rec_line_drive.sv
module rec_line_drive
    import bus_rec_pkg::*;
(
    input  rec_step_e step_i,
    output logic      scl_ovr_o,
    output logic      sda_ovr_o,
    output logic      busy_o
);
    line_drive_t drv;

    always_comb begin
        drv       = drive_for(step_i);
        scl_ovr_o = drv.scl_low;
        sda_ovr_o = drv.sda_low;
        busy_o    = (step_i != STEP_IDLE);
    end

    // R1
    always_comb begin
        idle_quiet_chk: assert (busy_o || (!scl_ovr_o && !sda_ovr_o));
    end

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import bus_rec_pkg::*;
#(
    parameter int PHASE_CYCLES = 500,
    parameter int PULSES       = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic scl_ovr,
    output logic sda_ovr,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_ok
);
    rec_step_e step;
    logic      phase_end;
    logic      run;

    rec_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .phase_end_o (phase_end)
    );

    rec_step_seq #(.PULSES(PULSES)) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .phase_end_i (phase_end),
        .step_o      (step),
        .done_o      (done)
    );

    rec_line_drive i_drive (
        .step_i    (step),
        .scl_ovr_o (scl_ovr),
        .sda_ovr_o (sda_ovr),
        .busy_o    (run)
    );

    assign busy   = run;
    assign bus_ok = done & scl_in & sda_in;

    // R4
    sda_under_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_ovr) |-> scl_ovr && $past(scl_ovr));

    // R6
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_ovr) |-> !scl_ovr && !$past(scl_ovr));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    // R9
    bus_ok_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !bus_ok);

endmodule

// File: tb/test_bus_recovery_seq.sv
module test_bus_recovery_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 3;
    localparam int NP         = 9;
    localparam int TOTAL      = (2 * NP + 2) * PH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, scl_ovr, sda_ovr, bus_ok;
    logic scl_in, sda_in;
    int   rel = 0;
    int   pulses_seen = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Line model: pull-ups, overrides, and a target holding data low.
    assign scl_in = ~scl_ovr;
    assign sda_in = ~sda_ovr & ~(pulses_seen < rel);

    bus_recovery_seq #(.PHASE_CYCLES(PH), .PULSES(NP)) i_bus_recovery_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .scl_ovr(scl_ovr), .sda_ovr(sda_ovr), .scl_in(scl_in),
        .sda_in(sda_in), .bus_ok(bus_ok)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_scl(input int o);
        int ph = o / PH;
        if (ph < 2 * NP) return logic'(ph % 2);
        return ph == 2 * NP;
    endfunction

    function automatic logic exp_sda(input int o);
        return (o / PH) >= 2 * NP;
    endfunction

    function automatic string req_of(input int o);
        int ph = o / PH;
        if (ph < 2 * NP) return "R3";
        if (ph == 2 * NP) return "R4";
        return "R5";
    endfunction

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1", "busy", busy, 1'b0);
            chk("R1", "scl_ovr", scl_ovr, 1'b0);
            chk("R1", "sda_ovr", sda_ovr, 1'b0);
            chk("R7", "done", done, 1'b0);
            chk("R9", "bus_ok", bus_ok, 1'b0);
        end
    endtask

    task automatic run_seq(input bit hold, input bit prestarted, input bit noisy, input int release_after);
        if (!prestarted) begin
            @(negedge clk);
            start = 1'b1;
        end
        @(posedge clk);
        pulses_seen = 0;
        rel = release_after;
        for (int o = 0; o <= TOTAL; o++) begin
            @(negedge clk);
            if (hold) start = 1'b1;
            else if (noisy && o < TOTAL) start = ($urandom % 3) == 0;
            else start = 1'b0;
            if (o < TOTAL) begin
                if ((o / PH) < 2 * NP && ((o / PH) % 2) == 1 && (o % PH) == 0)
                    pulses_seen = pulses_seen + 1;
                chk(req_of(o), "scl_ovr", scl_ovr, exp_scl(o));
                chk(req_of(o), "sda_ovr", sda_ovr, exp_sda(o));
                chk(noisy ? "R8" : "R2", "busy", busy, 1'b1);
                chk("R7", "done early", done, 1'b0);
                chk("R9", "bus_ok idle", bus_ok, 1'b0);
            end else begin
                chk("R6", "scl_ovr end", scl_ovr, 1'b0);
                chk("R6", "sda_ovr end", sda_ovr, 1'b0);
                chk("R7", "done", done, 1'b1);
                chk("R7", "busy end", busy, 1'b0);
                chk("R9", "bus_ok", bus_ok, logic'(release_after <= NP));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c2b_5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset busy", busy, 1'b0);
        chk("R1", "reset scl_ovr", scl_ovr, 1'b0);
        chk("R1", "reset sda_ovr", sda_ovr, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        rst = 1'b0;
        idle_cycles(4);
        // Directed: target releases after three pulses.
        run_seq(1'b0, 1'b0, 1'b0, 3);
        idle_cycles(2);
        // Directed: target never lets go, bus_ok stays 0 (R9).
        run_seq(1'b0, 1'b0, 1'b0, NP + 5);
        idle_cycles(1);
        // Directed: starts sprinkled through the run are ignored (R8).
        run_seq(1'b0, 1'b0, 1'b1, 9);
        idle_cycles(3);
        // Directed: start held, back-to-back sequences (R10).
        run_seq(1'b1, 1'b0, 1'b0, 0);
        run_seq(1'b0, 1'b1, 1'b0, 1);
        idle_cycles(2);
        // Random mix.
        for (int k = 0; k < 25; k++) begin
            idle_cycles(int'($urandom % 6));
            run_seq(1'b0, 1'b0, bit'($urandom % 2), int'($urandom % 12));
        end
        idle_cycles(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule